// File: doc/BRIEF.md
# I2C Event Vector and Status Unit

This block gathers the one-cycle event pulses raised by an I2C controller's bus engine and turns them into state that software can inspect: a status word, an enable mask and an encoded vector. Each event has a sticky pending flag. A level interrupt line is raised while any enabled event is pending.

The interrupt handler reads the vector register. That read returns the code of the most urgent enabled event and clears that event's flag. The handler repeats the read, taking one event per read, until the code 0 comes back. Two of the status flags can also be cleared by writing ones to the status word. A small synchronous register bus gives access. Read data is registered and appears one cycle after the access.

Top module: `i2c_evt_vector_unit`

## Requirements
- R1: After reset all pending flags and the enable mask are 0, `irq_o` is 0 and `bus_rdata` is 0.
- R2: The enable mask is at byte offset 0x04. Bits 6:0 are read/write, bits 15:7 read as 0, and a write takes effect on the clock edge that samples it.
- R3: Bit i of `evt_pulse` sets the pending flag of event i on the next clock edge. The event indices are 0 arbitration lost, 1 no-acknowledge, 2 registers ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. Mask bit i belongs to event i.
- R4: The status word is at offset 0x08. It shows the pending flags of arbitration lost in bit 0, no-acknowledge in bit 1, registers ready in bit 2 and stop detected in bit 5. It shows the `rx_shift_full` input in bit 11 and the `bus_busy` input in bit 12. All other bits read as 0.
- R5: The vector register at offset 0x28 returns i+1 for the lowest-index event i that is both pending and enabled, or 0 when there is none.
- R6: A vector read clears the pending flag of the event it reports. Repeated reads therefore return the pending enabled events in ascending code order and then 0.
- R7: Writing 1 to status bit 2 or bit 5 clears the registers-ready or stop-detected flag. Writing 0 there, or writing any value to status bits 0 and 1, leaves the flags unchanged.
- R8: A disabled event still sets its flag and its status bit, but it takes no part in the vector or in `irq_o`.
- R9: `irq_o` is 1 exactly when the vector value would be nonzero. It follows the pending flags and the mask in the same cycle.
- R10: When an event pulse and a clear (a vector read or a status write of 1) hit the same flag on the same edge, the flag stays set.
- R11: A read of an unmapped offset returns 0. A write to an unmapped offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| evt_pulse | input | 7 | One-cycle event pulses, indexed as in R3 |
| rx_shift_full | input | 1 | Level: receive shift register full |
| bus_busy | input | 1 | Level: bus busy |
| irq_o | output | 1 | Level interrupt request |

## Verification
An event pulse sampled at edge k makes its flag visible after edge k. `irq_o` therefore changes right after that edge, and a status or vector read strobed at edge k+1 or later sees the flag. Read data is due one edge after the strobe, and the clear that a vector read causes takes effect on that same edge. The next read can therefore follow at once. The bench drives every input on the falling edge. It samples `irq_o` and `bus_rdata` on the falling edge after the relevant rising edge, so each sample lands half a cycle after the result becomes due. The same-edge collision cases put the pulse and the clearing access on one falling-edge drive, so both are sampled by the same rising edge.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
   localparam int NUM_EV = 7;
   localparam int CODE_W = 3;

   localparam int EV_ARB  = 0;
   localparam int EV_NACK = 1;
   localparam int EV_RDY  = 2;
   localparam int EV_RX   = 3;
   localparam int EV_TX   = 4;
   localparam int EV_STOP = 5;
   localparam int EV_SLV  = 6;

   typedef logic [NUM_EV-1:0] ev_vec_t;
   typedef logic [CODE_W-1:0] ev_code_t;
endpackage

// File: rtl/ivu_flags.sv
module ivu_flags
   import ivu_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  ev_vec_t set_i,
   input  ev_vec_t clr_i,
   output ev_vec_t pend_o
);
   ev_vec_t pend_q;

   for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)         pend_q[g] <= 1'b0;
         else if (set_i[g])  pend_q[g] <= 1'b1;
         else if (clr_i[g])  pend_q[g] <= 1'b0;
      end

      // R3 R10
      evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> pend_q[g]);

      // R6 R7
      clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[g] && !set_i[g]) |=> !pend_q[g]);
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/ivu_prio.sv
module ivu_prio
   import ivu_pkg::*;
(
   input  ev_vec_t  req_i,
   output ev_vec_t  grant_o,
   output ev_code_t code_o
);
   always_comb begin
      grant_o = '0;
      code_o  = '0;
      for (int i = NUM_EV - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            grant_o    = '0;
            grant_o[i] = 1'b1;
            code_o     = CODE_W'(i + 1);
         end
      end
   end

   // R5
   grant_onehot_chk: assert final ($onehot0(grant_o));
   // R5
   grant_iff_req_chk: assert final ((grant_o != '0) == (req_i != '0));
endmodule

// File: rtl/ivu_regs.sv
module ivu_regs
   import ivu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 8,
   parameter int OFS_MASK   = 'h04,
   parameter int OFS_STAT   = 'h08,
   parameter int OFS_VEC    = 'h28,
   parameter int SB_ARB     = 0,
   parameter int SB_NACK    = 1,
   parameter int SB_RDY     = 2,
   parameter int SB_STOP    = 5,
   parameter int SB_RSFULL  = 11,
   parameter int SB_BUSY    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  ev_vec_t           pend_i,
   input  ev_vec_t           grant_i,
   input  ev_code_t          code_i,
   input  logic              rsfull_i,
   input  logic              busy_i,
   output ev_vec_t           mask_o,
   output ev_vec_t           clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VEC);

   if (DATA_W <= SB_BUSY || DATA_W <= SB_RSFULL || DATA_W < NUM_EV) begin : g_bad_width
      $error("ivu_regs: DATA_W too narrow for status layout");
   end
   if (OFS_MASK == OFS_STAT || OFS_MASK == OFS_VEC || OFS_STAT == OFS_VEC) begin : g_bad_ofs
      $error("ivu_regs: register offsets must differ");
   end
   if ((1 << ADDR_W) <= OFS_VEC) begin : g_bad_addr
      $error("ivu_regs: ADDR_W cannot reach vector offset");
   end

   logic hit_mask, hit_stat, hit_vec;
   logic mask_wr, stat_wr, vec_rd, rd;
   ev_vec_t mask_q, w1c;
   logic [DATA_W-1:0] stat_word, rd_mux, rdata_q;

   assign hit_mask = (addr_i == A_MASK);
   assign hit_stat = (addr_i == A_STAT);
   assign hit_vec  = (addr_i == A_VEC);
   assign rd       = sel_i && !wr_i;
   assign mask_wr  = sel_i && wr_i && hit_mask;
   assign stat_wr  = sel_i && wr_i && hit_stat;
   assign vec_rd   = rd && hit_vec;

   always_comb begin
      w1c = '0;
      w1c[EV_RDY]  = stat_wr && wdata_i[SB_RDY];
      w1c[EV_STOP] = stat_wr && wdata_i[SB_STOP];
   end

   assign clr_o = w1c | (vec_rd ? grant_i : '0);

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= wdata_i[NUM_EV-1:0];
   end
   assign mask_o = mask_q;

   always_comb begin
      stat_word            = '0;
      stat_word[SB_ARB]    = pend_i[EV_ARB];
      stat_word[SB_NACK]   = pend_i[EV_NACK];
      stat_word[SB_RDY]    = pend_i[EV_RDY];
      stat_word[SB_STOP]   = pend_i[EV_STOP];
      stat_word[SB_RSFULL] = rsfull_i;
      stat_word[SB_BUSY]   = busy_i;
   end

   always_comb begin
      rd_mux = '0;
      if (hit_mask)     rd_mux[NUM_EV-1:0] = mask_q;
      else if (hit_stat) rd_mux = stat_word;
      else if (hit_vec)  rd_mux[CODE_W-1:0] = code_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= rd_mux;
   end
   assign rdata_o = rdata_q;

   // R2
   mask_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> mask_q == $past(wdata_i[NUM_EV-1:0]));

   // R5
   vec_read_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd |=> rdata_q[CODE_W-1:0] == $past(code_i));

   // R11
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !hit_mask && !hit_stat && !hit_vec) |=> rdata_q == '0);
endmodule

// File: rtl/i2c_evt_vector_unit.sv
module i2c_evt_vector_unit
   import ivu_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 8,
   parameter int OFS_MASK = 'h04,
   parameter int OFS_STAT = 'h08,
   parameter int OFS_VEC  = 'h28,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_EV-1:0] evt_pulse,
   input  logic              rx_shift_full,
   input  logic              bus_busy,
   output logic              irq_o
);
   ev_vec_t  pend, mask, clr, grant, live;
   ev_code_t code;

   ivu_flags u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_pulse),
      .clr_i  (clr),
      .pend_o (pend)
   );

   assign live = pend & mask;

   ivu_prio u_prio (
      .req_i   (live),
      .grant_o (grant),
      .code_o  (code)
   );

   ivu_regs #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .OFS_MASK (OFS_MASK),
      .OFS_STAT (OFS_STAT),
      .OFS_VEC  (OFS_VEC)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (bus_sel),
      .wr_i     (bus_wr),
      .addr_i   (bus_addr),
      .wdata_i  (bus_wdata),
      .pend_i   (pend),
      .grant_i  (grant),
      .code_i   (code),
      .rsfull_i (rx_shift_full),
      .busy_i   (bus_busy),
      .mask_o   (mask),
      .clr_o    (clr),
      .rdata_o  (bus_rdata)
   );

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= (code != '0);
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = (code != '0);

      // R9
      irq_tracks_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o == (grant != '0));
   end

   // R8
   masked_never_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~mask) == '0);

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (pend == '0 && mask == '0 && bus_rdata == '0));
endmodule

// File: tb/i2c_evt_vector_unit_tb.sv
module i2c_evt_vector_unit_tb;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam logic [AW-1:0] A_MASK = 8'h04;
   localparam logic [AW-1:0] A_STAT = 8'h08;
   localparam logic [AW-1:0] A_VEC  = 8'h28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [6:0] evt_pulse = '0;
   logic rx_shift_full = 1'b0, bus_busy = 1'b0;
   logic irq_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2c_evt_vector_unit u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_pulse(evt_pulse), .rx_shift_full(rx_shift_full),
      .bus_busy(bus_busy), .irq_o(irq_o)
   );

   // mask, pulses, expected first vector code, expected irq
   typedef struct packed {
      logic [6:0] mask;
      logic [6:0] pulses;
      logic [2:0] code;
      logic       irq;
   } vec_t;

   localparam vec_t TABLE [8] = '{
      '{7'h7F, 7'b0000001, 3'd1, 1'b1},
      '{7'h7F, 7'b1000000, 3'd7, 1'b1},
      '{7'h7F, 7'b0010100, 3'd3, 1'b1},
      '{7'h7F, 7'b1111110, 3'd2, 1'b1},
      '{7'h7E, 7'b0000011, 3'd2, 1'b1},
      '{7'h00, 7'b0101010, 3'd0, 1'b0},
      '{7'h50, 7'b1011111, 3'd5, 1'b1},
      '{7'h20, 7'b0100000, 3'd6, 1'b1}
   };

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic [6:0] p);
      @(negedge clk);
      evt_pulse = p;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   initial begin
      logic [DW-1:0] d;
      do_reset();
      // R1: reset state
      check("R1 irq", {15'd0, irq_o}, 16'd1 - 16'd1);
      check("R1 rdata", bus_rdata, 16'h0000);
      rd(A_MASK, d); check("R1 mask", d, 16'h0000);
      rd(A_VEC, d);  check("R1 vector", d, 16'h0000);

      // table walk: R3 R5 R8 R9
      foreach (TABLE[i]) begin
         do_reset();
         wr(A_MASK, {9'd0, TABLE[i].mask});
         pulse(TABLE[i].pulses);
         check($sformatf("R9 irq row %0d", i), {15'd0, irq_o}, {15'd0, TABLE[i].irq});
         rd(A_VEC, d);
         check($sformatf("R5 R8 vector row %0d", i), d, {13'd0, TABLE[i].code});
      end

      // R2: mask readback, reserved bits zero
      do_reset();
      wr(A_MASK, 16'hFFFF);
      rd(A_MASK, d); check("R2 mask readback", d, 16'h007F);

      // R4 R8: status with all masked
      do_reset();
      rx_shift_full = 1'b1; bus_busy = 1'b1;
      pulse(7'b1111111);
      check("R8 irq masked", {15'd0, irq_o}, 16'h0000);
      rd(A_STAT, d); check("R4 status", d, 16'h1827);

      // R7: W1C on bits 0,1,2 -> only bit 2 clears
      wr(A_STAT, 16'h0007);
      rd(A_STAT, d); check("R7 w1c ready only", d, 16'h1823);
      wr(A_STAT, 16'h0000);
      rd(A_STAT, d); check("R7 write zero no effect", d, 16'h1823);
      wr(A_STAT, 16'h0020);
      rd(A_STAT, d); check("R7 w1c stop", d, 16'h1803);
      rx_shift_full = 1'b0; bus_busy = 1'b0;
      rd(A_STAT, d); check("R4 level bits follow", d, 16'h0003);

      // R6: drain sequence (pending: 0,1,3,4,6)
      wr(A_MASK, 16'h007F);
      check("R9 irq after enable", {15'd0, irq_o}, 16'h0001);
      rd(A_VEC, d); check("R6 drain 1", d, 16'h0001);
      rd(A_VEC, d); check("R6 drain 2", d, 16'h0002);
      rd(A_VEC, d); check("R6 drain 3", d, 16'h0004);
      rd(A_VEC, d); check("R6 drain 4", d, 16'h0005);
      rd(A_VEC, d); check("R6 drain 5", d, 16'h0007);
      rd(A_VEC, d); check("R6 drain end", d, 16'h0000);
      check("R9 irq drained", {15'd0, irq_o}, 16'h0000);

      // R10: pulse collides with vector read on same flag
      pulse(7'b0000001);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_VEC; evt_pulse = 7'b0000001;
      @(negedge clk);
      bus_sel = 1'b0; evt_pulse = '0;
      check("R10 read reports", bus_rdata, 16'h0001);
      check("R10 irq stays", {15'd0, irq_o}, 16'h0001);
      rd(A_VEC, d); check("R10 flag kept", d, 16'h0001);
      rd(A_VEC, d); check("R10 then empty", d, 16'h0000);

      // R10: pulse collides with W1C on registers ready
      pulse(7'b0000100);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 16'h0004;
      evt_pulse = 7'b0000100;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; evt_pulse = '0;
      rd(A_STAT, d); check("R10 w1c collision", d, 16'h0004);

      // R11: unmapped offsets
      wr(8'h10, 16'hFFFF);
      rd(A_MASK, d); check("R11 unmapped write", d, 16'h007F);
      rd(8'h10, d);  check("R11 unmapped read", d, 16'h0000);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule